// File: doc/BRIEF.md
# Scratchpad-Backed Mutex Engine

This engine serves lock and unlock requests for mutex records that live in a single-port scratchpad with a fixed read latency. Each request comes from an upstream packet decoder. It carries a record pointer and the identifier of the requesting thread and CPU. The pointer addresses the record directly, so the engine never searches for it. The engine runs the scratchpad accesses one at a time and decides the outcome. When a reply packet is due, it raises a one-cycle strobe. The reply's routing and serialisation belong to the surrounding interface.

Each record is a block of consecutive words. The base word holds an allocation flag and a self pointer, and the engine does not touch it. The word at base+1 describes the wait queue. The word at base+2 holds the current owner. Waiting threads are stored outside the engine, in a queue unit that the engine reaches through an enqueue/dequeue port. The engine keeps the waiter count in the record.

A lock on a free mutex grants ownership at once. A lock on a mutex held by another thread queues the requester and sends no reply. A second lock from the current owner is rejected with an error reply. An unlock passes ownership to the oldest waiter and replies to that waiter. If nobody is waiting, the unlock clears the owner.

Top module: `mutex_engine`

## Requirements
- R1: After reset, req_ready_o is 1 and mem_req_o, rsp_valid_o, wq_enq_o and wq_deq_o are all 0.
- R2: Record layout, relative to the request pointer: word +1 holds the waiter count in bits [15:0], with bits [31:16] left unchanged by the engine. Word +2 holds the owner identifier in bits [15:0], where 0 means free. Thread identifier 0 is reserved.
- R3: A lock on a free mutex makes exactly 2 scratchpad accesses: a read of word +2, then a write of {16'h0, requester} to word +2. It then strobes a reply with rsp_err_o=0 and rsp_tid_o equal to the requester.
- R4: A lock on a mutex owned by a different thread makes exactly 3 accesses and gives one wq_enq_o pulse carrying the requester and the pointer. It increments the waiter count and leaves the owner unchanged. It sends no reply.
- R5: A lock by the current owner makes exactly 1 access. It strobes a reply with rsp_err_o=1 and rsp_tid_o equal to the requester. It does not enqueue and leaves the memory unchanged.
- R6: An unlock with a waiter count of 0 makes exactly 2 accesses, leaves the owner at 0, and sends no reply.
- R7: An unlock with waiters makes exactly 3 accesses and gives one wq_deq_o pulse. It writes the dequeued identifier as the owner and decrements the count. It strobes a grant reply addressed to the dequeued thread.
- R8: At most one scratchpad access is in flight. A new mem_req_o pulse comes no sooner than 3 cycles after the previous one. Read data is taken 2 cycles after the request cycle.
- R9: req_ready_o drops in the cycle after a request is accepted and stays low until the request completes. A request presented while ready is low is not accepted and has no effect.
- R10: A reply strobe lasts exactly one cycle, and rsp_ptr_o equals the pointer of the request that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine can accept a request |
| req_unlock_i | input | 1 | 1 = unlock, 0 = lock |
| req_ptr_i | input | ADDR_W | Record base word address |
| req_tid_i | input | TID_W | Requesting thread/CPU identifier |
| rsp_valid_o | output | 1 | Reply packet ready (one cycle) |
| rsp_err_o | output | 1 | Reply is an error (re-lock by owner) |
| rsp_ptr_o | output | ADDR_W | Record pointer of the reply |
| rsp_tid_o | output | TID_W | Destination thread of the reply |
| mem_req_o | output | 1 | Scratchpad access strobe |
| mem_we_o | output | 1 | Scratchpad write enable |
| mem_addr_o | output | ADDR_W | Scratchpad word address |
| mem_wdata_o | output | DATA_W | Scratchpad write data |
| mem_rdata_i | input | DATA_W | Scratchpad read data, 2 cycles after the request |
| wq_enq_o | output | 1 | Append wq_tid_o to the queue of wq_ptr_o |
| wq_deq_o | output | 1 | Pop the head of the queue of wq_ptr_o |
| wq_ptr_o | output | ADDR_W | Record whose queue is addressed |
| wq_tid_o | output | TID_W | Identifier to enqueue |
| wq_tid_i | input | TID_W | Current head of the addressed queue |

## Verification
The hardest state to reach is a deep wait queue being drained one waiter at a time. Each unlock then has to pull the right identifier from the external queue, move ownership to it, and still keep the untouched upper half of the queue word. The bench builds this state from the ports. On each of four records it takes the lock with one thread and then queues up to four other threads. It also tries a re-lock by the owner while the queue is full. It then releases the lock repeatedly until the record is free again. While a contended lock is in progress, a competing request is held on the input so that the engine's refusal to accept it can be seen in the memory image.

// File: rtl/mutex_engine_pkg.sv
package mutex_engine_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_VAL, ST_RD_Q, ST_WR_VAL, ST_WR_Q, ST_REPLY
  } state_e;

  typedef enum logic [1:0] {
    LK_GRANT, LK_QUEUE, LK_REJECT
  } lock_e;

  localparam int unsigned QWORD_OFS = 1;
  localparam int unsigned VWORD_OFS = 2;
endpackage

// File: rtl/mutex_mem_seq.sv
module mutex_mem_seq #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MEM_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned CNT_W = $clog2(MEM_LAT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o      <= 1'b0;
      cnt_q       <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_req_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o      <= 1'b1;
        cnt_q       <= CNT_W'(MEM_LAT);
        mem_req_o   <= 1'b1;
        mem_we_o    <= we_i;
        mem_addr_o  <= addr_i;
        mem_wdata_o <= wdata_i;
      end else if (busy_o) begin
        if (cnt_q == '0) busy_o <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign done_o  = busy_o && (cnt_q == '0);
  assign rdata_o = mem_rdata_i;
endmodule

// File: rtl/mutex_lock_decide.sv
module mutex_lock_decide
  import mutex_engine_pkg::*;
#(
  parameter int unsigned TID_W = 16
) (
  input  logic [TID_W-1:0] owner_i,
  input  logic [TID_W-1:0] tid_i,
  output lock_e            outcome_o
);
  always_comb begin
    if (owner_i == '0)         outcome_o = LK_GRANT;
    else if (owner_i == tid_i) outcome_o = LK_REJECT;
    else                       outcome_o = LK_QUEUE;
  end
endmodule

// File: rtl/mutex_engine.sv
module mutex_engine
  import mutex_engine_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned TID_W   = 16,
  parameter int unsigned MEM_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_unlock_i,
  input  logic [ADDR_W-1:0] req_ptr_i,
  input  logic [TID_W-1:0]  req_tid_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [ADDR_W-1:0] rsp_ptr_o,
  output logic [TID_W-1:0]  rsp_tid_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wq_enq_o,
  output logic              wq_deq_o,
  output logic [ADDR_W-1:0] wq_ptr_o,
  output logic [TID_W-1:0]  wq_tid_o,
  input  logic [TID_W-1:0]  wq_tid_i
);
  localparam int unsigned CNT_W = 16;

  state_e            state_q;
  logic              op_sent_q, unlock_q, waiter_q, err_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [TID_W-1:0]  tid_q, owner_q;
  logic [DATA_W-1:0] qword_q;

  logic              seq_start, seq_we, seq_busy, seq_done;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_wdata, seq_rdata;
  lock_e             outcome;
  logic [CNT_W-1:0]  rd_cnt;

  assign rd_cnt = seq_rdata[CNT_W-1:0];

  mutex_lock_decide #(.TID_W(TID_W)) i_decide (
    .owner_i   (seq_rdata[TID_W-1:0]),
    .tid_i     (tid_q),
    .outcome_o (outcome)
  );

  always_comb begin
    seq_start = 1'b0;
    seq_we    = 1'b0;
    seq_addr  = ptr_q + ADDR_W'(VWORD_OFS);
    seq_wdata = '0;
    unique case (state_q)
      ST_RD_VAL: seq_start = !op_sent_q;
      ST_RD_Q: begin
        seq_start = !op_sent_q;
        seq_addr  = ptr_q + ADDR_W'(QWORD_OFS);
      end
      ST_WR_VAL: begin
        seq_start = !op_sent_q;
        seq_we    = 1'b1;
        seq_wdata = DATA_W'(owner_q);
      end
      ST_WR_Q: begin
        seq_start = !op_sent_q;
        seq_we    = 1'b1;
        seq_addr  = ptr_q + ADDR_W'(QWORD_OFS);
        seq_wdata = qword_q;
      end
      default: ;
    endcase
  end

  mutex_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (seq_start),
    .we_i        (seq_we),
    .addr_i      (seq_addr),
    .wdata_i     (seq_wdata),
    .busy_o      (seq_busy),
    .done_o      (seq_done),
    .rdata_o     (seq_rdata),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );

  assign wq_enq_o = (state_q == ST_RD_VAL) && seq_done && (outcome == LK_QUEUE);
  assign wq_deq_o = (state_q == ST_RD_Q) && seq_done && unlock_q && (rd_cnt != '0);
  assign wq_ptr_o = ptr_q;
  assign wq_tid_o = tid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_sent_q <= 1'b0;
      unlock_q  <= 1'b0;
      waiter_q  <= 1'b0;
      err_q     <= 1'b0;
      ptr_q     <= '0;
      tid_q     <= '0;
      owner_q   <= '0;
      qword_q   <= '0;
    end else begin
      if (seq_start && !seq_busy) op_sent_q <= 1'b1;
      if (seq_done) op_sent_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          unlock_q <= req_unlock_i;
          ptr_q    <= req_ptr_i;
          tid_q    <= req_tid_i;
          err_q    <= 1'b0;
          state_q  <= req_unlock_i ? ST_RD_Q : ST_RD_VAL;
        end
        ST_RD_VAL: if (seq_done) begin
          unique case (outcome)
            LK_GRANT: begin
              owner_q <= tid_q;
              state_q <= ST_WR_VAL;
            end
            LK_REJECT: begin
              err_q   <= 1'b1;
              state_q <= ST_REPLY;
            end
            default: state_q <= ST_RD_Q;
          endcase
        end
        ST_RD_Q: if (seq_done) begin
          if (!unlock_q) begin
            qword_q <= {seq_rdata[DATA_W-1:CNT_W], rd_cnt + 1'b1};
            state_q <= ST_WR_Q;
          end else begin
            waiter_q <= (rd_cnt != '0);
            owner_q  <= (rd_cnt != '0) ? wq_tid_i : '0;
            qword_q  <= {seq_rdata[DATA_W-1:CNT_W], rd_cnt - 1'b1};
            state_q  <= ST_WR_VAL;
          end
        end
        ST_WR_VAL: if (seq_done) begin
          if (!unlock_q)     state_q <= ST_REPLY;
          else if (waiter_q) state_q <= ST_WR_Q;
          else               state_q <= ST_IDLE;
        end
        ST_WR_Q: if (seq_done) state_q <= unlock_q ? ST_REPLY : ST_IDLE;
        ST_REPLY: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_REPLY);
  assign rsp_err_o   = err_q;
  assign rsp_ptr_o   = ptr_q;
  assign rsp_tid_o   = err_q ? tid_q : owner_q;
endmodule

// File: rtl/mutex_engine_chk.sv
module mutex_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic mem_req_o,
  input logic wq_enq_o,
  input logic wq_deq_o
);
  a_r8_single_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r8_access_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> ##1 !mem_req_o);
  a_r9_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r9_idle_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);
  a_r10_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r10_reply_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  a_r7_queue_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wq_enq_o && wq_deq_o));
endmodule

bind mutex_engine mutex_engine_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .mem_req_o   (mem_req_o),
  .wq_enq_o    (wq_enq_o),
  .wq_deq_o    (wq_deq_o)
);

// File: tb/test_mutex_engine.sv
`timescale 1ns/1ps
module test_mutex_engine;
  localparam int ADDR_W = 8, DATA_W = 32, TID_W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_unlock_i = 1'b0;
  logic [ADDR_W-1:0] req_ptr_i = '0;
  logic [TID_W-1:0]  req_tid_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_err_o, mem_req_o, mem_we_o, wq_enq_o, wq_deq_o;
  logic [ADDR_W-1:0] rsp_ptr_o, mem_addr_o, wq_ptr_o;
  logic [TID_W-1:0]  rsp_tid_o, wq_tid_o, wq_tid_i;
  logic [DATA_W-1:0] mem_wdata_o, mem_rdata_i;

  always #5 clk_i = ~clk_i;

  mutex_engine i_mutex_engine (.*);

  // scratchpad model, 2-cycle read latency
  logic [DATA_W-1:0] mem [256];
  logic [DATA_W-1:0] rd1, rd2;
  assign mem_rdata_i = rd2;
  always @(posedge clk_i) begin
    if (mem_req_o && mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    rd1 <= mem[mem_addr_o];
    rd2 <= rd1;
  end

  // wait-queue model, one FIFO per record
  logic [TID_W-1:0] qm [4][8];
  logic [2:0] qh [4], qt [4];
  assign wq_tid_i = qm[wq_ptr_o[4:3]][qh[wq_ptr_o[4:3]]];
  always @(posedge clk_i) begin
    if (wq_enq_o) begin
      qm[wq_ptr_o[4:3]][qt[wq_ptr_o[4:3]]] <= wq_tid_o;
      qt[wq_ptr_o[4:3]] <= qt[wq_ptr_o[4:3]] + 1'b1;
    end
    if (wq_deq_o) qh[wq_ptr_o[4:3]] <= qh[wq_ptr_o[4:3]] + 1'b1;
  end

  int checks = 0, errors = 0;
  int n_mem, n_enq, n_deq, n_rsp, since_req = 10, gap_err = 0;
  logic r_err; logic [TID_W-1:0] r_tid; logic [ADDR_W-1:0] r_ptr;

  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (since_req < 3) gap_err++;
      since_req = 0;
      n_mem++;
    end else since_req++;
    if (wq_enq_o) n_enq++;
    if (wq_deq_o) n_deq++;
    if (rsp_valid_o) begin
      n_rsp++; r_err = rsp_err_o; r_tid = rsp_tid_o; r_ptr = rsp_ptr_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_req(input bit unl, input logic [ADDR_W-1:0] ptr,
                        input logic [TID_W-1:0] tid, input bit jam);
    while (!req_ready_o) @(negedge clk_i);
    n_mem = 0; n_enq = 0; n_deq = 0; n_rsp = 0;
    req_valid_i = 1'b1; req_unlock_i = unl; req_ptr_i = ptr; req_tid_i = tid;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R9 ready low after accept", int'(req_ready_o), 0);
    if (jam) begin
      req_valid_i = 1'b1; req_unlock_i = 1'b0; req_ptr_i = 8'd200; req_tid_i = 16'd99;
      repeat (3) @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    while (!req_ready_o) @(negedge clk_i);
  endtask

  function automatic int qcnt(input int p); return int'(mem[p+1][15:0]); endfunction
  function automatic int own(input int p);  return int'(mem[p+2]); endfunction

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 32'h0;
    for (int r = 0; r < 4; r++) begin
      mem[8*r+4] = {16'h0, 8'(8*r+4), 7'd0, 1'b1};
      mem[8*r+5] = {16'hC300 + 16'(r), 16'h0};
      qh[r] = '0; qt[r] = '0;
    end
    mem[201] = 32'h1234_0000; mem[202] = 32'h0;
    rd1 = '0; rd2 = '0;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1 && mem_req_o == 0 && rsp_valid_o == 0 && wq_enq_o == 0 && wq_deq_o == 0,
        "R1 reset state", int'(req_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1 ready after reset", int'(req_ready_o), 1);

    for (int r = 0; r < 4; r++) begin
      automatic int p = 8*r + 4;
      automatic int w = r + 1;
      automatic logic [TID_W-1:0] ow = TID_W'(16*r + 1);
      // R3 uncontended lock
      do_req(1'b0, ADDR_W'(p), ow, 1'b0);
      chk(n_mem == 2, "R3 access count", n_mem, 2);
      chk(n_rsp == 1 && r_err == 0 && r_tid == ow, "R3 grant reply", int'(r_tid), int'(ow));
      chk(r_ptr == ADDR_W'(p), "R10 reply pointer", int'(r_ptr), p);
      chk(own(p) == int'(ow), "R2 R3 owner word", own(p), int'(ow));
      // R4 contended locks
      for (int k = 1; k <= w; k++) begin
        do_req(1'b0, ADDR_W'(p), ow + TID_W'(k), k == 1);
        chk(n_mem == 3 && n_enq == 1 && n_rsp == 0, "R4 queued lock", n_mem, 3);
        chk(qcnt(p) == k, "R4 waiter count", qcnt(p), k);
        chk(mem[p+1][31:16] == 16'hC300 + 16'(r), "R2 upper half kept", int'(mem[p+1][31:16]),
            int'(16'hC300 + 16'(r)));
        chk(own(p) == int'(ow), "R4 owner unchanged", own(p), int'(ow));
        if (k == 1)
          chk(mem[201] == 32'h1234_0000 && mem[202] == 0, "R9 held request ignored",
              int'(mem[201][31:16]), 16'h1234);
      end
      // R5 relock by owner
      do_req(1'b0, ADDR_W'(p), ow, 1'b0);
      chk(n_mem == 1 && n_enq == 0, "R5 access count", n_mem, 1);
      chk(n_rsp == 1 && r_err == 1 && r_tid == ow, "R5 error reply", int'(r_err), 1);
      chk(qcnt(p) == w && own(p) == int'(ow), "R5 memory unchanged", qcnt(p), w);
      // R7 handover
      for (int k = 1; k <= w; k++) begin
        do_req(1'b1, ADDR_W'(p), 16'd0, 1'b0);
        chk(n_mem == 3 && n_deq == 1, "R7 access count", n_mem, 3);
        chk(n_rsp == 1 && r_err == 0 && r_tid == ow + TID_W'(k), "R7 grant to waiter",
            int'(r_tid), int'(ow) + k);
        chk(own(p) == int'(ow) + k, "R7 new owner", own(p), int'(ow) + k);
        chk(qcnt(p) == w - k, "R7 waiter count", qcnt(p), w - k);
      end
      // R6 release with empty queue
      do_req(1'b1, ADDR_W'(p), 16'd0, 1'b0);
      chk(n_mem == 2 && n_deq == 0 && n_rsp == 0, "R6 empty unlock", n_mem, 2);
      chk(own(p) == 0 && qcnt(p) == 0, "R6 owner cleared", own(p), 0);
    end
    chk(gap_err == 0, "R8 access spacing", gap_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule